// File: doc/BRIEF.md
# Per-Stage Timing-Error Recovery Controller

This block coordinates recovery after a late-arriving result is caught in the stage registers of a five-stage in-order pipeline. Fetch, decode, execute and memory-read can each report that a value they just registered may be wrong. Writeback is protected by a stabilising register, and architectural state is only written there, so it never reports. A reporting stage handles the error locally in the same cycle: its outgoing result is replaced by a bubble, so the suspect value can never reach writeback.

Each report also sends a request, registered one cycle, to a central flush unit. The request carries the index of the reporting stage and the PC of its instruction. One cycle later the flush unit squashes that stage and every stage above it (toward fetch). By then those stages hold only instructions younger than the failed one. The unit also redirects fetch to the saved PC, so the failed instruction is fetched and executed again. When several stages report in the same cycle, the one closest to writeback wins. A wrapping event counter records how many recoveries were started.

Top module: `terr_recovery`

## Requirements
- R1: While reset is low at a clock edge, the flush mask, the redirect strobe and the recovery count are all zero after that edge.
- R2: A stage whose error flag and valid flag are both high, and which is not being flushed, asserts its bubble output in the same cycle. Bubble bit k belongs to stage k: 0 fetch, 1 decode, 2 execute, 3 memory-read.
- R3: An error flag on a stage whose valid flag is low raises no bubble, and no flush or redirect in the following cycle.
- R4: In the cycle after an accepted error, the redirect strobe is high and the redirect PC equals the PC that the winning stage presented in the error cycle. Stage k's PC occupies bits [k*PCW +: PCW] of the PC input.
- R5: In that same following cycle, the flush mask has bit j set exactly for j at or below the winning stage index: that stage and all younger ones.
- R6: When several stages raise accepted errors together, the one with the highest index wins the redirect PC and the flush extent.
- R7: In a cycle where the flush mask is active, error flags from flushed stages are ignored: they raise no bubble and no request. Errors from unflushed stages are accepted normally and produce their own redirect in the next cycle.
- R8: The recovery count increments by exactly one for each cycle that has at least one accepted error, is visible with the redirect, and wraps modulo 2^CNTW.
- R9: With no accepted error in a cycle, the following cycle has no redirect and no flush.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stg_err_i | input | NSTG | Timing-error flag from each stage register |
| stg_valid_i | input | NSTG | Stage holds a real instruction |
| stg_pc_i | input | NSTG*PCW | PC of each stage's instruction, stage k at [k*PCW +: PCW] |
| bubble_o | output | NSTG | Replace the stage's outgoing result with a bubble (same cycle) |
| flush_o | output | NSTG | Squash the stage's instruction |
| redir_valid_o | output | 1 | Restart fetch this cycle |
| redir_pc_o | output | PCW | Restart address |
| recov_cnt_o | output | CNTW | Wrapping count of recoveries started |

## Verification
The main sweep applies every combination of the four error flags and the four valid flags from a quiet pipeline. Comparing each against the highest-set-bit arithmetic separates valid gating, oldest-wins arbitration and the contiguous flush extent. A second sweep places each possible winner and then applies all sixteen error patterns during its flush cycle. This shows whether flushed stages are masked while older stages still start their own recovery. The running count is compared after every case, and its wrap-around falls inside the sweep.

// File: rtl/trec_pkg.sv
// Package: default sizing shared by the recovery controller and its bench.
// Assumes four reporting stages (writeback never reports).
package trec_pkg;
    localparam int unsigned TREC_NSTG = 4;   // fetch, decode, execute, memory-read
    localparam int unsigned TREC_PCW  = 16;  // PC width carried by requests
    localparam int unsigned TREC_CNTW = 8;   // recovery counter width
endpackage

// File: rtl/trec_oldest_pick.sv
// Module: trec_oldest_pick
// Picks the highest-index (closest to writeback, hence oldest) set bit of
// a request vector. Purely combinational; any_o is low when nothing is set
// and idx_o is then zero.
module trec_oldest_pick #(
    parameter int unsigned N  = 4,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req_i,
    output logic          any_o,
    output logic [IW-1:0] idx_o
);
    // Scan upward so the last (highest) set bit wins.
    always_comb begin
        idx_o = '0;
        for (int k = 0; k < N; k++) begin
            if (req_i[k]) idx_o = IW'(k);
        end
    end

    // Any request present at all.
    assign any_o = |req_i;
endmodule

// File: rtl/trec_flush_ctrl.sv
// Module: trec_flush_ctrl
// Central flush unit. Registers one winning request per cycle. In the
// following cycle it squashes the requesting stage index and every younger
// stage, and redirects fetch to the saved PC. Assumes requests are already
// arbitrated and masked by the caller.
module trec_flush_ctrl #(
    parameter int unsigned N   = 4,
    parameter int unsigned PCW = 16,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_any_i,
    input  logic [IW-1:0]  req_idx_i,
    input  logic [PCW-1:0] req_pc_i,
    output logic [N-1:0]   flush_o,
    output logic           redir_valid_o,
    output logic [PCW-1:0] redir_pc_o
);
    logic           pend_v;
    logic [IW-1:0]  pend_idx;
    logic [PCW-1:0] pend_pc;

    // Capture the winning request for action in the next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_idx <= '0;
            pend_pc  <= '0;
        end else begin
            pend_v   <= req_any_i;
            pend_idx <= req_idx_i;
            pend_pc  <= req_pc_i;
        end
    end

    // One squash bit per stage: set for the failing index and all younger.
    for (genvar k = 0; k < N; k++) begin : g_flush
        assign flush_o[k] = pend_v && (int'(pend_idx) >= k);
    end

    assign redir_valid_o = pend_v;
    assign redir_pc_o    = pend_pc;

    // The squash mask always covers a contiguous run starting at fetch.
    p_flush_contig_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(flush_o + N'(1)));

    // A redirect always squashes fetch as well.
    p_flush_if_r5: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid_o |-> flush_o[0]);
endmodule

// File: rtl/trec_event_cnt.sv
// Module: trec_event_cnt
// Wrapping counter of recovery events; counts one per asserted inc_i cycle.
module trec_event_cnt #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    // Advance by one on each recovery, wrapping at 2^W.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_o <= '0;
        else if (inc_i) cnt_o <= cnt_o + W'(1);
    end

    p_cnt_inc_r8: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |=> cnt_o == $past(cnt_o) + W'(1));

    p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !inc_i |=> $stable(cnt_o));
endmodule

// File: rtl/terr_recovery.sv
// Module: terr_recovery
// Distributed timing-error recovery for an in-order pipeline. Each valid
// stage that reports an error bubbles its own output in the same cycle.
// The oldest such stage sends its index and PC to the flush unit, which
// squashes it and all younger stages in the next cycle and restarts fetch
// at that PC. Assumes stage 0 is fetch and higher indices are older.
module terr_recovery #(
    parameter int unsigned NSTG = trec_pkg::TREC_NSTG,
    parameter int unsigned PCW  = trec_pkg::TREC_PCW,
    parameter int unsigned CNTW = trec_pkg::TREC_CNTW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSTG-1:0]     stg_err_i,
    input  logic [NSTG-1:0]     stg_valid_i,
    input  logic [NSTG*PCW-1:0] stg_pc_i,
    output logic [NSTG-1:0]     bubble_o,
    output logic [NSTG-1:0]     flush_o,
    output logic                redir_valid_o,
    output logic [PCW-1:0]      redir_pc_o,
    output logic [CNTW-1:0]     recov_cnt_o
);
    localparam int unsigned IW = (NSTG > 1) ? $clog2(NSTG) : 1;

    logic [PCW-1:0] pc_arr [NSTG];
    logic           win_any;
    logic [IW-1:0]  win_idx;
    logic [PCW-1:0] win_pc;

    // Split the packed PC bus into one entry per stage.
    for (genvar k = 0; k < NSTG; k++) begin : g_pc
        assign pc_arr[k] = stg_pc_i[k*PCW +: PCW];
    end

    // Local handling: valid, unsquashed erroring stages bubble right away.
    assign bubble_o = stg_err_i & stg_valid_i & ~flush_o;

    trec_oldest_pick #(.N(NSTG)) i_pick (
        .req_i (bubble_o),
        .any_o (win_any),
        .idx_o (win_idx)
    );

    assign win_pc = pc_arr[win_idx];

    trec_flush_ctrl #(.N(NSTG), .PCW(PCW)) i_flush (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_any_i     (win_any),
        .req_idx_i     (win_idx),
        .req_pc_i      (win_pc),
        .flush_o       (flush_o),
        .redir_valid_o (redir_valid_o),
        .redir_pc_o    (redir_pc_o)
    );

    trec_event_cnt #(.W(CNTW)) i_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (win_any),
        .cnt_o (recov_cnt_o)
    );

    // An empty stage never bubbles.
    p_bubble_needs_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble_o & ~stg_valid_i) == '0);

    // Any local bubble leads to a redirect one cycle later.
    p_redir_after_bubble_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (|bubble_o) |=> redir_valid_o);

    // A quiet cycle is followed by no redirect.
    p_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(|bubble_o) |=> !redir_valid_o);

    // Flushed stages never raise a bubble of their own.
    p_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bubble_o & flush_o) == '0);
endmodule

// File: tb/test_terr_recovery.sv
`timescale 1ns/1ps
module test_terr_recovery;
    localparam int NS  = 4;
    localparam int PCW = 16;
    localparam int CW  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NS-1:0]    stg_err, stg_valid, bubble, flush;
    logic [NS*PCW-1:0] stg_pc;
    logic             redir_v;
    logic [PCW-1:0]   redir_pc;
    logic [CW-1:0]    cnt;

    int n_checks = 0;
    int n_errs   = 0;
    logic [CW-1:0] cnt_m = '0;

    always #2.5 clk = ~clk;

    terr_recovery #(.NSTG(NS), .PCW(PCW), .CNTW(CW)) i_terr_recovery (
        .clk(clk), .rst_n(rst_n), .stg_err_i(stg_err), .stg_valid_i(stg_valid),
        .stg_pc_i(stg_pc), .bubble_o(bubble), .flush_o(flush),
        .redir_valid_o(redir_v), .redir_pc_o(redir_pc), .recov_cnt_o(cnt)
    );

    function automatic logic [PCW-1:0] pc_of(int s, int tag);
        return PCW'(16'h1000 + tag * 16 + s * 4);
    endfunction

    function automatic int hi_bit(logic [NS-1:0] v);
        int h = 0;
        for (int k = 0; k < NS; k++) if (v[k]) h = k;
        return h;
    endfunction

    task automatic chk(string req, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_pcs(int tag);
        for (int s = 0; s < NS; s++) stg_pc[s*PCW +: PCW] = pc_of(s, tag);
    endtask

    initial begin
        #(5.0 * 150000);
        n_errs++; n_checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        int tag = 0;
        rst_n = 1'b0; stg_err = '0; stg_valid = '0; stg_pc = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        chk("R1 flush", flush, 0);
        chk("R1 redirect", redir_v, 0);
        chk("R1 count", cnt, 0);
        rst_n = 1'b1;

        // Sweep 1: every error/valid combination from a quiet pipeline.
        for (int e = 0; e < 16; e++) begin
            for (int v = 0; v < 16; v++) begin
                logic [NS-1:0] live;
                int w;
                tag++;
                @(negedge clk);
                stg_err = NS'(e); stg_valid = NS'(v); load_pcs(tag);
                #1;
                live = NS'(e & v);
                chk((e & ~v) != 0 ? "R3 bubble gating" : "R2 bubble", bubble, live);
                chk("R9 no flush before request", flush, 0);
                @(negedge clk);
                stg_err = '0; stg_valid = '0;
                #1;
                if (live != 0) begin
                    w = hi_bit(live);
                    cnt_m++;
                    chk("R4 redirect strobe", redir_v, 1);
                    chk("R6 redirect pc oldest", redir_pc, pc_of(w, tag));
                    chk("R5 flush extent", flush, (1 << (w + 1)) - 1);
                end else begin
                    chk(e != 0 ? "R3 no redirect" : "R9 no redirect", redir_v, 0);
                    chk(e != 0 ? "R3 no flush" : "R9 no flush", flush, 0);
                end
                chk("R8 count", cnt, cnt_m);
            end
        end

        // Sweep 2: errors arriving during a flush cycle.
        for (int w = 0; w < NS; w++) begin
            for (int e2 = 0; e2 < 16; e2++) begin
                logic [NS-1:0] mask, live2;
                tag++;
                @(negedge clk);
                stg_err = NS'(1 << w); stg_valid = '1; load_pcs(tag);
                @(negedge clk);
                tag++;
                stg_err = NS'(e2); load_pcs(tag);
                #1;
                mask  = NS'((1 << (w + 1)) - 1);
                live2 = NS'(e2) & ~mask;
                cnt_m++;
                chk("R5 flush extent", flush, mask);
                chk("R4 redirect pc", redir_pc, pc_of(w, tag - 1));
                chk("R7 masked bubble", bubble, live2);
                chk("R8 count", cnt, cnt_m);
                @(negedge clk);
                stg_err = '0; stg_valid = '0;
                #1;
                if (live2 != 0) begin
                    cnt_m++;
                    chk("R7 older stage redirect", redir_v, 1);
                    chk("R7 older stage pc", redir_pc, pc_of(hi_bit(live2), tag));
                    chk("R7 older stage flush", flush, (1 << (hi_bit(live2) + 1)) - 1);
                end else begin
                    chk("R7 flushed errors ignored", redir_v, 0);
                    chk("R7 flushed errors no flush", flush, 0);
                end
                chk("R8 count", cnt, cnt_m);
                @(negedge clk);
            end
        end

        // Reset after activity returns outputs to idle.
        @(negedge clk);
        stg_err = '1; stg_valid = '1;
        @(negedge clk);
        rst_n = 1'b0; stg_err = '0; stg_valid = '0;
        @(negedge clk); #1;
        chk("R1 count after reset", cnt, 0);
        chk("R1 redirect after reset", redir_v, 0);
        chk("R1 flush after reset", flush, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule